// File: doc/BRIEF.md
# Counter Range-Compare Pattern Unit

The unit watches the present values of four counters. Each counter owns a table of sixteen ranges. A range entry holds an inclusive lower limit, an inclusive upper limit and a 12-bit output pattern. On every clock the unit tests each enabled counter's value against its sixteen ranges and selects the pattern of the first matching range, or zero when no range matches. It registers the selection as that counter's result word.

Pattern bits 7..0 are the counter's private field. Bits 11..8 form a shared field. The four external outputs are the bitwise OR of the shared fields of all four result words. Software loads table entries one field at a time through a write port. That port addresses a counter, a range and a field.

Top module: `range_pattern_unit`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears every result word, the external outputs and every table field to zero. After reset, an entry whose limits are never written matches only a present value of 0.
- R2: A range matches when lower <= pv <= upper, using unsigned 32-bit comparison, with both ends included. The result word for an enabled counter holds the pattern of the selected range one clock after the present value is applied.
- R3: When no range of an enabled counter matches, that counter's result word is zero.
- R4: When several ranges match, the range with the lowest index supplies the pattern. Range index 0 stands for range 1 and index 15 for range 16.
- R5: The result word of counter c sits at result[12*c+11 : 12*c]. Output ext_out[j] (j = 0..3) is the OR over the four counters of result bit 8+j. Both are registered and change together.
- R6: While en[c] is low, counter c's result word is zero one clock later, so it adds nothing to ext_out.
- R7: A write is performed at a rising edge with wr_en high. wr_fld = 0 writes the lower limit, 1 writes the upper limit and 2 writes the pattern, taken from wr_data[11:0]. wr_fld = 3 changes nothing. A written value is first used at the edge after the write edge.
- R8: The limit 32'hFFFFFFFF can be matched. An entry whose lower limit is greater than its upper limit never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 4 | Per-counter compare enable |
| pv | input | 128 | Present values; counter c at bits 32*c+31 : 32*c |
| wr_en | input | 1 | Table write strobe |
| wr_cnt | input | 2 | Counter index of the write |
| wr_rng | input | 4 | Range index of the write (0 = range 1) |
| wr_fld | input | 2 | Field: 0 lower, 1 upper, 2 pattern, 3 none |
| wr_data | input | 32 | Write data |
| result | output | 48 | Registered result words; counter c at bits 12*c+11 : 12*c |
| ext_out | output | 4 | Registered OR of the shared pattern fields |

## Verification
The bench builds the unit with its default parameters: four counters, sixteen ranges, 32-bit values and 12-bit patterns split 8/4. With these parameters the full unsigned range is reachable, so values at 0 and at 32'hFFFFFFFF exercise the ends of the compare, and range index 15 exercises the lowest priority. Four counters with distinct shared bits make the external OR observable both when shared bits coincide and when they are disjoint. A behavioural model mirrors every table write and predicts each result word, one cycle later, on every clock.

// File: rtl/range_pattern_unit.sv
module range_pattern_unit #(
  parameter int NCNT = 4,
  parameter int NRNG = 16,
  parameter int VW   = 32,
  parameter int PW   = 12,
  parameter int IW   = 8,
  localparam int CW  = $clog2(NCNT),
  localparam int RW  = $clog2(NRNG),
  localparam int EW  = PW - IW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NCNT-1:0]    en,
  input  logic [NCNT*VW-1:0] pv,
  input  logic               wr_en,
  input  logic [CW-1:0]      wr_cnt,
  input  logic [RW-1:0]      wr_rng,
  input  logic [1:0]         wr_fld,
  input  logic [VW-1:0]      wr_data,
  output logic [NCNT*PW-1:0] result,
  output logic [EW-1:0]      ext_out
);

  logic [VW-1:0]   lo  [NCNT][NRNG];
  logic [VW-1:0]   hi  [NCNT][NRNG];
  logic [PW-1:0]   pat [NCNT][NRNG];
  logic [NRNG-1:0] hit [NCNT];
  logic [NRNG-1:0] sel [NCNT];
  logic [PW-1:0]   nxt [NCNT];
  logic [PW-1:0]   res_q [NCNT];
  logic [EW-1:0]   ext_nxt;
  logic [EW-1:0]   ext_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCNT; c++)
        for (int r = 0; r < NRNG; r++) begin
          lo[c][r]  <= '0;
          hi[c][r]  <= '0;
          pat[c][r] <= '0;
        end
    end else if (wr_en) begin
      case (wr_fld)
        2'd0: lo[wr_cnt][wr_rng]  <= wr_data;
        2'd1: hi[wr_cnt][wr_rng]  <= wr_data;
        2'd2: pat[wr_cnt][wr_rng] <= wr_data[PW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    for (int c = 0; c < NCNT; c++) begin
      logic found;
      found  = 1'b0;
      sel[c] = '0;
      nxt[c] = '0;
      for (int r = 0; r < NRNG; r++) begin
        hit[c][r] = (pv[c*VW +: VW] >= lo[c][r]) && (pv[c*VW +: VW] <= hi[c][r]);
        if (hit[c][r] && !found && en[c]) begin
          sel[c][r] = 1'b1;
          found = 1'b1;
        end
      end
      for (int r = 0; r < NRNG; r++)
        if (sel[c][r]) nxt[c] = nxt[c] | pat[c][r];
    end
  end

  always_comb begin
    ext_nxt = '0;
    for (int c = 0; c < NCNT; c++) ext_nxt = ext_nxt | nxt[c][PW-1:IW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCNT; c++) res_q[c] <= '0;
      ext_q <= '0;
    end else begin
      for (int c = 0; c < NCNT; c++) res_q[c] <= nxt[c];
      ext_q <= ext_nxt;
    end
  end

  for (genvar c = 0; c < NCNT; c++) begin : g_out
    assign result[c*PW +: PW] = res_q[c];
  end
  assign ext_out = ext_q;

  logic [EW-1:0] shared_or;
  always_comb begin
    shared_or = '0;
    for (int c = 0; c < NCNT; c++) shared_or = shared_or | result[c*PW+IW +: EW];
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (result == '0 && ext_out == '0));

  a_r5_ext_is_or: assert property (@(posedge clk) disable iff (rst)
    ext_out == shared_or);

  for (genvar c = 0; c < NCNT; c++) begin : g_chk
    a_r6_disabled_zero: assert property (@(posedge clk) disable iff (rst)
      !en[c] |=> res_q[c] == '0);
    a_r3_no_hit_zero: assert property (@(posedge clk) disable iff (rst)
      (hit[c] == '0) |=> res_q[c] == '0);
    a_r4_single_select: assert property (@(posedge clk) disable iff (rst)
      $onehot0(sel[c]));
    a_r4_first_range_wins: assert property (@(posedge clk) disable iff (rst)
      (en[c] && hit[c][0]) |=> res_q[c] == $past(pat[c][0]));
  end

endmodule

// File: tb/test_range_pattern_unit.sv
module test_range_pattern_unit;
  localparam int NC = 4, NR = 16;
  logic clk = 0, rst = 1;
  logic [3:0] en = '0;
  logic [127:0] pv = '0;
  logic wr_en = 0;
  logic [1:0] wr_cnt = 0, wr_fld = 0;
  logic [3:0] wr_rng = 0;
  logic [31:0] wr_data = 0;
  logic [47:0] result;
  logic [3:0] ext_out;

  range_pattern_unit i_range_pattern_unit (
    .clk(clk), .rst(rst), .en(en), .pv(pv), .wr_en(wr_en), .wr_cnt(wr_cnt),
    .wr_rng(wr_rng), .wr_fld(wr_fld), .wr_data(wr_data),
    .result(result), .ext_out(ext_out));

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] mlo [NC][NR];
  logic [31:0] mhi [NC][NR];
  logic [11:0] mpat [NC][NR];
  logic [11:0] exp_res [NC];
  logic [3:0] exp_ext;

  task automatic predict();
    exp_ext = '0;
    for (int c = 0; c < NC; c++) begin
      logic [31:0] v;
      exp_res[c] = '0;
      v = pv[c*32 +: 32];
      if (!rst && en[c])
        for (int r = NR - 1; r >= 0; r--)
          if (v >= mlo[c][r] && v <= mhi[c][r]) exp_res[c] = mpat[c][r];
      exp_ext |= exp_res[c][11:8];
    end
  endtask

  task automatic step(input string tag);
    predict();
    @(posedge clk);
    if (rst) begin
      for (int c = 0; c < NC; c++)
        for (int r = 0; r < NR; r++) begin
          mlo[c][r] = 0; mhi[c][r] = 0; mpat[c][r] = 0;
        end
    end else if (wr_en) begin
      case (wr_fld)
        2'd0: mlo[wr_cnt][wr_rng] = wr_data;
        2'd1: mhi[wr_cnt][wr_rng] = wr_data;
        2'd2: mpat[wr_cnt][wr_rng] = wr_data[11:0];
        default: ;
      endcase
    end
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      checks++;
      if (result[c*12 +: 12] !== exp_res[c]) begin
        failures++;
        $display("FAIL %s counter %0d result act=%h exp=%h", tag, c, result[c*12 +: 12], exp_res[c]);
      end
    end
    checks++;
    if (ext_out !== exp_ext) begin
      failures++;
      $display("FAIL %s ext_out act=%b exp=%b", tag, ext_out, exp_ext);
    end
  endtask

  task automatic wr(input int c, input int r, input int f, input logic [31:0] d, input string tag);
    wr_en = 1; wr_cnt = 2'(c); wr_rng = 4'(r); wr_fld = 2'(f); wr_data = d;
    step(tag);
    wr_en = 0;
  endtask

  task automatic entry(input int c, input int r, input logic [31:0] l, input logic [31:0] h, input logic [11:0] p);
    wr(c, r, 0, l, "R7");
    wr(c, r, 1, h, "R7");
    wr(c, r, 2, {20'hFFFFF, p}, "R7");
  endtask

  task automatic setpv(input int c, input logic [31:0] v);
    pv[c*32 +: 32] = v;
  endtask

  initial begin
    @(negedge clk);
    rst = 1; en = 4'hF; pv = {4{32'h1234}};
    step("R1"); step("R1");
    rst = 0;
    pv = '0;
    step("R1");
    wr(0, 5, 2, 32'h0000_0ABC, "R1");
    step("R1");
    pv[31:0] = 32'd1; step("R1");
    wr(0, 5, 2, 32'h0, "R7");

    for (int c = 0; c < NC; c++)
      for (int r = 0; r < NR; r++)
        entry(c, r, 32'(c * 10000 + r * 100 + 10), 32'(c * 10000 + r * 100 + 60),
              {4'(1 << c) | 4'(r[0] ? 4'h8 : 4'h0), 8'(c * 16 + r)});

    for (int c = 0; c < NC; c++) setpv(c, 32'(c * 10000 + 310)); step("R2");
    for (int c = 0; c < NC; c++) setpv(c, 32'(c * 10000 + 360)); step("R2");
    for (int c = 0; c < NC; c++) setpv(c, 32'(c * 10000 + 309)); step("R3");
    for (int c = 0; c < NC; c++) setpv(c, 32'(c * 10000 + 361)); step("R3");
    setpv(0, 32'd10); setpv(1, 32'd99999); setpv(2, 32'd20010); setpv(3, 32'd0);
    step("R5");

    entry(1, 9, 32'd10000, 32'd20000, 12'h777);
    entry(1, 2, 32'd10150, 32'd10300, 12'h555);
    setpv(1, 32'd10220); step("R4");
    setpv(1, 32'd10950); step("R4");
    setpv(1, 32'd10250); step("R4");

    for (int c = 0; c < NC; c++) setpv(c, 32'(c * 10000 + 30));
    step("R6");
    en = 4'b0101; step("R6"); step("R6");
    en = 4'b0000; step("R6");
    en = 4'hF; step("R6");

    wr_en = 1; wr_cnt = 2; wr_rng = 0; wr_fld = 3; wr_data = 32'hFFFF_FFFF;
    step("R7");
    wr_en = 0; step("R7");
    setpv(2, 32'd20030);
    wr(2, 0, 2, 32'h0000_0F0F, "R7");
    step("R7");

    entry(3, 15, 32'hFFFF_FFF0, 32'hFFFF_FFFF, 12'h8AA);
    entry(3, 14, 32'd500, 32'd400, 12'h4BB);
    setpv(3, 32'hFFFF_FFFF); step("R8");
    setpv(3, 32'hFFFF_FFEF); step("R8");
    setpv(3, 32'd450); step("R8");
    setpv(3, 32'd500); step("R8");

    for (int i = 0; i < 3000; i++) begin
      for (int c = 0; c < NC; c++) begin
        int r, o;
        r = $urandom_range(0, NR - 1);
        o = $urandom_range(0, 4);
        case (o)
          0: setpv(c, mlo[c][r] - 1);
          1: setpv(c, mlo[c][r]);
          2: setpv(c, mhi[c][r]);
          3: setpv(c, mhi[c][r] + 1);
          default: setpv(c, $urandom());
        endcase
      end
      en = 4'($urandom_range(0, 15) | ((i % 4 != 0) ? 15 : 0));
      if (i % 97 == 5) begin
        int c, r;
        c = $urandom_range(0, 3);
        r = $urandom_range(0, 15);
        wr(c, r, 2, $urandom(), "R7");
      end else step("R2");
    end

    rst = 1; step("R1");
    rst = 0; pv = '0; step("R1");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule